// File: doc/BRIEF.md
# Host Interrupt Request Controller

This block gathers a vector of level-sensitive interrupt sources into a sticky status register, masks it with an enable register, and drives a single interrupt pin toward the host processor. Software reads and acknowledges status through a small register port. A status bit can only be cleared once its source has gone quiet, so an acknowledge can never lose a condition that is still pending. A software-forced source lets a driver raise the pin on its own, for example to confirm that its handler is hooked to the right interrupt line.

The pin can be configured as push-pull with either polarity, or as open-drain. In open-drain mode the block drives a low level through an output enable and ignores the polarity setting. A hold-off timer, counted in 10 µs ticks from an internal clock divider, enforces a minimum gap between the pin releasing and asserting again. This caps the share of host time spent on interrupt service under heavy load.

Top module: `irqc_top`

## Requirements
- R1: After reset, the configuration (address 0), status (address 1) and enable (address 2) registers read 0, and the pin is released: irqOut=0 and irqOe=0.
- R2: Status bit i (bits NUM_SRC-1:0) is set in the clock after srcIn[i] is sampled high, whether or not it is enabled. It stays set after the source falls until software clears it.
- R3: Writing 1 to a status bit clears it only if its source is low at that write. A source that is still high keeps its bit set.
- R4: The pin becomes active only when at least one status bit has its matching enable bit set. Once active, it stays active until the enabled status bits are all clear, even if the sources have fallen.
- R5: A write to the enable register takes effect one clock later. For a bit that is already pending, the pin changes on the clock edge after the write edge.
- R6: With configuration bit 0 = 1 (push-pull), irqOe is held at 1 and irqOut equals configuration bit 1 when active and its inverse when inactive.
- R7: With configuration bit 0 = 0 (open-drain), irqOut is held at 0, irqOe is 1 exactly while active, and configuration bit 1 has no effect.
- R8: Enable bit 31 forces status bit 31 set and drives the pin with no hardware source. Status bit 31 refuses to clear while enable bit 31 is set.
- R9: With configuration bits 31:24 = H > 0, after the pin releases it cannot assert again for H*TICK_DIV clocks. If an interrupt is still pending, the pin asserts on the next edge after that interval.
- R10: With H = 0, a pending interrupt reasserts the pin on the clock edge right after it released.
- R11: Address 3 and all unassigned bits read as 0. Configuration bits 31:24, 1 and 0 read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 configuration, 1 status, 2 enable |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for addr, combinational |
| srcIn | input | NUM_SRC | Raw level interrupt sources |
| irqOut | output | 1 | Registered pin data value |
| irqOe | output | 1 | Registered pin output enable |

## Verification
The bench builds the block with NUM_SRC=4 and TICK_DIV=4. With a 4-clock tick, a hold-off field of 3 spans only 12 clocks, so the exact clock at which the pin may assert again can be checked on both sides of the boundary. The zero-field case is exercised next to it. Four sources leave room to mix enabled and unenabled sources with the forced software bit and to sweep all three pin driver settings in a short run.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DATA_W = 32;
  localparam int SW_BIT = 31;
  localparam logic [1:0] A_CFG  = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_EN   = 2'd2;

  // Strobes from the control FSM to the datapath pin register
  typedef struct packed {
    logic pinOn;
    logic pinOff;
  } irqc_strobe_t;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         addr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] srcIn,
  input  irqc_strobe_t       strobe,
  output logic [DATA_W-1:0]  rdData,
  output logic               pending,
  output logic [7:0]         holdVal,
  output logic               irqOut,
  output logic               irqOe
);
  logic [7:0]         cfgHold;
  logic               cfgPol;
  logic               cfgDrv;
  logic [NUM_SRC-1:0] enQ;
  logic               swEnQ;
  logic [NUM_SRC-1:0] statVec;
  logic               swStatQ;
  logic               pinAct;
  logic               actNext;
  logic               clrReq;
  logic               unusedWrBits;

  assign clrReq       = wrEn && (addr == A_STAT);
  assign unusedWrBits = ^wrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgHold <= '0;
      cfgPol  <= 1'b0;
      cfgDrv  <= 1'b0;
      enQ     <= '0;
      swEnQ   <= 1'b0;
    end else if (wrEn) begin
      if (addr == A_CFG) begin
        cfgHold <= wrData[31:24];
        cfgPol  <= wrData[1];
        cfgDrv  <= wrData[0];
      end
      if (addr == A_EN) begin
        enQ   <= wrData[NUM_SRC-1:0];
        swEnQ <= wrData[SW_BIT];
      end
    end
  end

  // One sticky status cell per source; clear refused while source is high
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_stat
    logic bitQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) bitQ <= 1'b0;
      else       bitQ <= srcIn[i] | (bitQ & ~(clrReq & wrData[i]));
    end
    assign statVec[i] = bitQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) swStatQ <= 1'b0;
    else       swStatQ <= swEnQ | (swStatQ & ~(clrReq & wrData[SW_BIT]));
  end

  assign pending = (|(statVec & enQ)) | (swStatQ & swEnQ);
  assign holdVal = cfgHold;

  assign actNext = strobe.pinOn | (pinAct & ~strobe.pinOff);

  // Pin drivers are flops so the pad sees no combinational glitch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinAct <= 1'b0;
      irqOut <= 1'b0;
      irqOe  <= 1'b0;
    end else begin
      pinAct <= actNext;
      if (cfgDrv) begin
        irqOut <= actNext ? cfgPol : ~cfgPol;
        irqOe  <= 1'b1;
      end else begin
        irqOut <= 1'b0;
        irqOe  <= actNext;
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      A_CFG: begin
        rdData[31:24] = cfgHold;
        rdData[1]     = cfgPol;
        rdData[0]     = cfgDrv;
      end
      A_STAT: begin
        rdData[NUM_SRC-1:0] = statVec;
        rdData[SW_BIT]      = swStatQ;
      end
      A_EN: begin
        rdData[NUM_SRC-1:0] = enQ;
        rdData[SW_BIT]      = swEnQ;
      end
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int TICK_DIV = 2000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         pending,
  input  logic [7:0]   holdVal,
  output irqc_strobe_t strobe
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

  typedef enum logic [1:0] { S_IDLE, S_ACTIVE, S_HOLD } state_t;

  state_t           state;
  logic [DIV_W-1:0] divCnt;
  logic [7:0]       holdCnt;
  logic             tick;

  assign tick = (divCnt == DIV_LAST);

  always_comb begin
    strobe.pinOn  = (state == S_IDLE) && pending;
    strobe.pinOff = (state == S_ACTIVE) && !pending;
  end

  // 10 us divider, restarted on release so the hold-off is exact
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      divCnt <= '0;
    else if (strobe.pinOff || tick) divCnt <= '0;
    else                            divCnt <= divCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      holdCnt <= '0;
    end else begin
      case (state)
        S_IDLE:   if (strobe.pinOn) state <= S_ACTIVE;
        S_ACTIVE: if (strobe.pinOff) begin
          holdCnt <= holdVal;
          state   <= (holdVal != 8'd0) ? S_HOLD : S_IDLE;
        end
        S_HOLD:   if (tick) begin
          holdCnt <= holdCnt - 8'd1;
          if (holdCnt == 8'd1) state <= S_IDLE;
        end
        default:  state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int TICK_DIV = 2000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         addr,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdData,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic               irqOut,
  output logic               irqOe
);
  irqc_strobe_t strobe;
  logic         pending;
  logic [7:0]   holdVal;

  irqc_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .srcIn(srcIn), .strobe(strobe), .rdData(rdData), .pending(pending),
    .holdVal(holdVal), .irqOut(irqOut), .irqOe(irqOe)
  );

  irqc_ctrl #(.TICK_DIV(TICK_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .pending(pending), .holdVal(holdVal),
    .strobe(strobe)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int TICK_DIV = 2000
) (
  input logic               clk,
  input logic               rstN,
  input logic [1:0]         addr,
  input logic [31:0]        rdData,
  input logic [NUM_SRC-1:0] srcIn,
  input logic               irqOut,
  input logic               irqOe,
  input logic               pending,
  input logic [7:0]         holdVal,
  input irqc_strobe_t       strobe
);
  logic        seenOff;
  logic [31:0] sinceOff;
  logic [7:0]  holdCap;
  logic [31:0] capClocks;

  assign capClocks = 32'(holdCap) * 32'(TICK_DIV);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenOff  <= 1'b0;
      sinceOff <= '0;
      holdCap  <= '0;
    end else if (strobe.pinOff) begin
      seenOff  <= 1'b1;
      sinceOff <= 32'd1;
      holdCap  <= holdVal;
    end else if (sinceOff != 32'hFFFF_FFFF) begin
      sinceOff <= sinceOff + 32'd1;
    end
  end

  // R2 and R3: a source seen high leaves its status bit set
  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    (addr == A_STAT) |-> ((rdData[NUM_SRC-1:0] & $past(srcIn)) == $past(srcIn)));

  assert_pin_pending_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pinOn |-> pending);

  assert_strobe_onehot_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.pinOn, strobe.pinOff}));

  assert_pushpull_oe_R6: assert property (@(posedge clk) disable iff (!rstN)
    (addr == A_CFG && rdData[0]) |=> irqOe);

  assert_opendrain_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    (addr == A_CFG && !rdData[0]) |=> !irqOut);

  assert_holdoff_gap_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pinOn && seenOff) |-> (sinceOff > capClocks));
endmodule

bind irqc_top irqc_checker #(.NUM_SRC(NUM_SRC), .TICK_DIV(TICK_DIV)) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .rdData(rdData), .srcIn(srcIn),
  .irqOut(irqOut), .irqOe(irqOe), .pending(pending), .holdVal(holdVal),
  .strobe(strobe)
);

// File: tb/irqc_top_tb.sv
`timescale 1ns/1ps
module irqc_top_tb;
  localparam int NSRC = 4;
  localparam int TDIV = 4;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            wrEn = 1'b0;
  logic [1:0]      addr = 2'd0;
  logic [31:0]     wrData = '0;
  logic [31:0]     rdData;
  logic [NSRC-1:0] srcIn = '0;
  logic            irqOut;
  logic            irqOe;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  typedef struct {
    bit          isRead;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  irqc_top #(.NUM_SRC(NSRC), .TICK_DIV(TDIV)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .srcIn(srcIn), .irqOut(irqOut), .irqOe(irqOe)
  );

  // Monitor: pops expected items and compares against the live outputs
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = q.pop_front();
        act = it.isRead ? rdData : {30'b0, irqOe, irqOut};
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic chkRd(input logic [1:0] a, input logic [31:0] e, input string r);
    addr = a;
    q.push_back('{1'b1, e, r});
    @(negedge clk);
  endtask

  // exp {oe,out}
  task automatic chkPin(input logic oe, input logic out, input string r);
    q.push_back('{1'b0, {30'b0, oe, out}, r});
  endtask

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    // R1 reset state
    chkRd(2'd0, 32'h0, "R1 cfg");
    chkRd(2'd1, 32'h0, "R1 stat");
    chkRd(2'd2, 32'h0, "R1 en");
    chkPin(1'b0, 1'b0, "R1 pin");
    chkRd(2'd3, 32'h0, "R11 addr3");

    // R6 push-pull active high, inactive
    wr(2'd0, 32'h0000_0003);
    cyc(1);
    chkPin(1'b1, 1'b0, "R6 inactive");
    chkRd(2'd0, 32'h0000_0003, "R11 cfg readback");

    // R2 status records an unenabled source
    srcIn[0] = 1'b1;
    cyc(2);
    chkRd(2'd1, 32'h1, "R2 unenabled set");
    chkPin(1'b1, 1'b0, "R4 unenabled no pin");

    // R5 enable acts one clock later
    wr(2'd2, 32'h1);
    chkPin(1'b1, 1'b0, "R5 not yet");
    cyc(1);
    chkPin(1'b1, 1'b1, "R5 asserted");

    // R3 clear refused while source high
    wr(2'd1, 32'h1);
    cyc(1);
    chkRd(2'd1, 32'h1, "R3 refused");
    chkPin(1'b1, 1'b1, "R3 pin held");

    // R4 pin stays until acknowledged
    srcIn[0] = 1'b0;
    cyc(3);
    chkPin(1'b1, 1'b1, "R4 held until ack");
    chkRd(2'd1, 32'h1, "R2 sticky after fall");
    wr(2'd1, 32'h1);
    cyc(2);
    chkRd(2'd1, 32'h0, "R3 cleared");
    chkPin(1'b1, 1'b0, "R4 released");

    // R6 push-pull active low
    wr(2'd0, 32'h0000_0001);
    cyc(1);
    chkPin(1'b1, 1'b1, "R6 low inactive");
    srcIn[1] = 1'b1;
    wr(2'd2, 32'h2);
    cyc(2);
    chkPin(1'b1, 1'b0, "R6 low active");

    // R7 open-drain, polarity bit set but ignored
    wr(2'd0, 32'h0000_0002);
    cyc(1);
    chkPin(1'b1, 1'b0, "R7 od active");
    srcIn[1] = 1'b0;
    cyc(1);
    wr(2'd1, 32'h2);
    cyc(2);
    chkPin(1'b0, 1'b0, "R7 od released");

    // R8 software-forced interrupt
    wr(2'd0, 32'h0000_0003);
    wr(2'd2, 32'h8000_0000);
    cyc(3);
    chkRd(2'd1, 32'h8000_0000, "R8 sw status");
    chkPin(1'b1, 1'b1, "R8 sw pin");
    wr(2'd1, 32'h8000_0000);
    cyc(1);
    chkRd(2'd1, 32'h8000_0000, "R8 sw clear refused");
    wr(2'd2, 32'h0);
    wr(2'd1, 32'h8000_0000);
    cyc(2);
    chkRd(2'd1, 32'h0, "R8 sw cleared");
    chkPin(1'b1, 1'b0, "R8 sw released");

    // R9 hold-off of 3 ticks = 12 clocks
    wr(2'd0, 32'h0300_0003);
    srcIn[2] = 1'b1;
    wr(2'd2, 32'h4);
    cyc(3);
    chkPin(1'b1, 1'b1, "R9 first assertion");
    srcIn[2] = 1'b0;
    cyc(1);
    wr(2'd1, 32'h4);
    srcIn[2] = 1'b1;
    cyc(7);
    chkPin(1'b1, 1'b0, "R9 mid window");
    cyc(6);
    chkPin(1'b1, 1'b0, "R9 last held clock");
    cyc(1);
    chkPin(1'b1, 1'b1, "R9 reassert");

    // R10 zero hold-off
    wr(2'd0, 32'h0000_0003);
    srcIn[2] = 1'b0;
    cyc(1);
    wr(2'd1, 32'h4);
    srcIn[2] = 1'b1;
    cyc(1);
    chkPin(1'b1, 1'b0, "R10 released");
    cyc(1);
    chkPin(1'b1, 1'b1, "R10 immediate reassert");

    cyc(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule